// File: doc/BRIEF.md
# Free-Running 40-Bit Time Base

This block is a memory-mapped up-counter that gives software a steady time reference. It never raises an interrupt. It advances by one on every clock cycle in which the external `tick` enable is high. In the intended system that enable pulses at about 983 kHz. A separate divider produces that pulse, and it is not part of this block.

Software sees the count through two registers. The low register at offset 0x60 holds bits 31:0. The high register at offset 0x64 holds bits 39:32 in its bits 7:0. It also holds the run/stop control in bit 8. Clearing that bit stops the counter and returns it to zero. Setting it again restarts the count from zero.

Reading the low register also latches the upper byte of the count into a snapshot. The high register always returns that snapshot, so reading low first and then high gives a consistent 40-bit value even if the count carries into the upper byte between the two reads. Read data appears on `rd_data` one cycle after the read strobe and is zero in every other cycle.

Top module: `timebase40`

## Requirements
- R1: After reset the count is zero, the counter is stopped, the snapshot is zero, and `rd_data` is zero.
- R2: While running, the count grows by exactly one in each cycle where `tick` is high and holds its value in cycles where `tick` is low.
- R3: While stopped, the count stays at zero and `tick` has no effect. A write to the high register with bit 8 clear forces the count to zero, and a later restart counts up from zero.
- R4: A write to the high register (offset 0x64) takes only bit 8 as the new run/stop state (1 = run). All other written bits are ignored.
- R5: A read of the low register (offset 0x60) returns count bits 31:0 on `rd_data` in the following cycle.
- R6: A read of the low register copies count bits 39:32 into the snapshot. A read of the high register returns the snapshot in bits 7:0, even if the count has moved since the low read.
- R7: A read of the high register returns the run/stop state in bit 8 and zero in bits 31:9.
- R8: The count is as wide as the low and high fields together (40 bits by default). After all ones it wraps to zero with no flag or side effect.
- R9: Writes to the low register or to any other offset change nothing. Reads of other offsets return zero, and `rd_data` is zero in any cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable pulse from the external rate divider |
| rd_en | input | 1 | Read strobe for `addr` |
| wr_en | input | 1 | Write strobe for `addr` |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after `rd_en`, zero otherwise |

## Verification
A count that drifts shows up at the next low read, where the value no longer matches the number of ticks seen since the last restart. A stuck run/stop flag shows up both in bit 8 of the next high read and in a count that moves when it should not, or stays still when it should move.

A snapshot that is taken at the wrong moment appears only on a high read that follows a carry into the upper field. The bench therefore uses a second, narrow instance that wraps within a few thousand ticks, so these carries and the full wrap happen within the run.

// File: rtl/timebase40.sv
module timebase40 #(
  parameter int                LO_W    = 32,
  parameter int                HI_W    = 8,
  parameter int                ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'('h60),
  parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'('h64)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rd_data
);
  localparam int CNT_W = LO_W + HI_W;
  localparam int DW    = 32;

  logic [CNT_W-1:0] cnt_q;
  logic [HI_W-1:0]  snap_q;
  logic             en_q;

  wire rd_lo = rd_en && (addr == LO_ADDR);
  wire rd_hi = rd_en && (addr == HI_ADDR);
  wire wr_hi = wr_en && (addr == HI_ADDR);
  wire en_d  = wr_hi ? wdata[HI_W] : en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      snap_q  <= '0;
      en_q    <= 1'b0;
      rd_data <= '0;
    end else begin
      en_q <= en_d;
      if (!en_d)
        cnt_q <= '0;
      else if (en_q && tick)
        cnt_q <= cnt_q + CNT_W'(1);
      if (rd_lo)
        snap_q <= cnt_q[CNT_W-1:LO_W];
      rd_data <= rd_lo ? DW'(cnt_q[LO_W-1:0]) :
                 rd_hi ? DW'({en_q, snap_q}) : '0;
    end
  end

  initial begin
    p_width_ok_r8: assert (LO_W >= 1 && LO_W <= 32 && HI_W >= 1 && HI_W <= 30);
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && en_d && tick) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && en_d && !tick) |=> $stable(cnt_q));

  p_stop_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> cnt_q == '0);

  p_snap_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo ##1 rd_hi |=> rd_data[HI_W-1:0] == $past(cnt_q[CNT_W-1:LO_W], 2));

  p_hi_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hi |=> (rd_data[DW-1:HI_W+1] == '0) && (rd_data[HI_W] == $past(en_q)));

  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> rd_data == '0);
endmodule

// File: tb/tb_timebase40.sv
module tb_timebase40;
  localparam int CLK_PERIOD = 10;
  localparam int S_LO = 8;
  localparam int S_HI = 4;
  localparam logic [7:0] A_LO = 8'h60;
  localparam logic [7:0] A_HI = 8'h64;
  localparam logic [7:0] A_OT = 8'h40;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdb, rds;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  timebase40 dut (.clk(clk), .rst_n(rst_n), .tick(tick), .rd_en(rd_en), .wr_en(wr_en),
                  .addr(addr), .wdata(wdata), .rd_data(rdb));
  timebase40 #(.LO_W(S_LO), .HI_W(S_HI)) dut_s (.clk(clk), .rst_n(rst_n), .tick(tick),
                  .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rd_data(rds));

  typedef struct packed {
    logic [63:0] cnt;
    logic        en;
    logic [63:0] snap;
  } mdl_t;
  mdl_t mb, ms;

  function automatic logic [31:0] exp_rd(mdl_t m, int lo, int hi, bit rd, logic [7:0] a);
    if (!rd) return '0;
    if (a == A_LO) return 32'(m.cnt & ((64'd1 << lo) - 64'd1));
    if (a == A_HI) return 32'((64'(m.en) << hi) | m.snap);
    return '0;
  endfunction

  function automatic mdl_t step(mdl_t m, int lo, int hi, bit t, bit rd, bit wr,
                                logic [7:0] a, logic [31:0] wd);
    mdl_t n = m;
    logic en_n = (wr && a == A_HI) ? wd[hi] : m.en;
    if (rd && a == A_LO) n.snap = (m.cnt >> lo) & ((64'd1 << hi) - 64'd1);
    n.en = en_n;
    if (!en_n) n.cnt = '0;
    else if (m.en && t) n.cnt = (m.cnt + 64'd1) & ((64'd1 << (lo + hi)) - 64'd1);
    return n;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic cyc(string tag, bit t, bit rd, bit wr, logic [7:0] a, logic [31:0] wd);
    logic [31:0] eb, es;
    tick = t; rd_en = rd; wr_en = wr; addr = a; wdata = wd;
    eb = exp_rd(mb, 32, 8, rd, a);
    es = exp_rd(ms, S_LO, S_HI, rd, a);
    mb = step(mb, 32, 8, t, rd, wr, a, wd);
    ms = step(ms, S_LO, S_HI, t, rd, wr, a, wd);
    @(negedge clk);
    check({tag, " wide"}, rdb, eb);
    check({tag, " narrow"}, rds, es);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    mb = '0; ms = '0;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset rd_data wide", rdb, 32'h0);
    check("R1 reset rd_data narrow", rds, 32'h0);
    rst_n = 1'b1;
    cyc("R1 low after reset", 0, 1, 0, A_LO, 0);
    check("R1 low zero", rdb, 32'h0);
    cyc("R1 high after reset", 0, 1, 0, A_HI, 0);
    check("R1 high zero", rdb, 32'h0);

    for (int i = 0; i < 5; i++) cyc("R3 ticks while stopped", 1, 0, 0, A_LO, 0);
    cyc("R3 low while stopped", 0, 1, 0, A_LO, 0);
    check("R3 count stays zero", rdb, 32'h0);

    cyc("R4 write without run bit", 1, 0, 1, A_HI, 32'hFFFF_FEEF);
    cyc("R4 read high", 0, 1, 0, A_HI, 0);
    check("R4 only bit 8 taken", rdb, 32'h0);
    cyc("R4 write run", 0, 0, 1, A_HI, 32'hFFFF_FFFF);
    cyc("R7 read high", 0, 1, 0, A_HI, 0);
    check("R7 run bit and zero upper", rdb, 32'h0000_0100);
    check("R7 narrow run bit", rds, 32'h0000_0010);

    for (int i = 0; i < 10; i++) cyc("R2 tick", 1, 0, 0, A_LO, 0);
    for (int i = 0; i < 4; i++) cyc("R2 no tick", 0, 0, 0, A_LO, 0);
    cyc("R5 read low", 0, 1, 0, A_LO, 0);
    check("R2 R5 ten ticks", rdb, 32'd10);

    cyc("R9 write low", 1, 0, 1, A_LO, 32'h1234_5678);
    cyc("R9 write other", 0, 0, 1, A_OT, 32'hFFFF_FFFF);
    cyc("R9 read low", 0, 1, 0, A_LO, 0);
    check("R9 writes ignored", rdb, 32'd11);
    cyc("R9 read other", 0, 1, 0, A_OT, 0);
    check("R9 other offset zero", rdb, 32'h0);

    cyc("R3 stop", 1, 0, 1, A_HI, 32'h0);
    cyc("R3 read low", 1, 1, 0, A_LO, 0);
    check("R3 cleared on stop", rdb, 32'h0);
    cyc("R3 restart", 1, 0, 1, A_HI, 32'h0000_0110);
    for (int i = 0; i < 3; i++) cyc("R3 tick after restart", 1, 0, 0, A_LO, 0);
    cyc("R3 read low", 0, 1, 0, A_LO, 0);
    check("R3 counts from zero", rdb, 32'd3);

    for (int i = 0; i < 4092; i++) cyc("R8 run to top", 1, 0, 0, A_LO, 0);
    cyc("R8 read low at top", 0, 1, 0, A_LO, 0);
    check("R8 narrow low at top", rds, 32'h0000_00FF);
    cyc("R8 wrap tick", 1, 0, 0, A_LO, 0);
    cyc("R6 read high after wrap", 0, 1, 0, A_HI, 0);
    check("R6 snapshot survives wrap", rds, 32'h0000_001F);
    cyc("R8 read low after wrap", 0, 1, 0, A_LO, 0);
    check("R8 narrow wrapped to zero", rds, 32'h0);
    cyc("R8 read high after wrap", 0, 1, 0, A_HI, 0);
    check("R8 narrow high zero", rds, 32'h0000_0010);
    check("R5 wide past carry", rdb, 32'h0000_0100);

    for (int i = 0; i < 3000; i++) begin
      int op = int'($urandom % 16);
      bit t  = ($urandom % 4) != 0;
      logic [31:0] wd = $urandom;
      if (op == 0) begin
        if (($urandom % 4) != 0) begin wd[8] = 1'b1; wd[4] = 1'b1; end
        cyc("R4 random write high", t, 0, 1, A_HI, wd);
      end else if (op == 1)
        cyc("R9 random write low", t, 0, 1, A_LO, wd);
      else if (op < 6)
        cyc("R5 random read low", t, 1, 0, A_LO, 0);
      else if (op < 9)
        cyc("R6 random read high", t, 1, 0, A_HI, 0);
      else if (op == 9)
        cyc("R9 random read other", t, 1, 0, A_OT, 0);
      else
        cyc("R2 random idle", t, 0, 0, A_LO, 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule